// File: doc/BRIEF.md
# DRAM Initialisation and Refresh Sequencer

This block brings an asynchronous-strobe DRAM out of power-up and then keeps its rows refreshed. After reset it holds both strobes inactive for a programmable settling pause. It then runs a burst of CAS-before-RAS cycles, during which the access controller must stay off the bus. When the burst is done it raises a ready flag. From then on an interval timer adds one owed refresh per period. The sequencer asks for the bus and takes it only when the access controller reports idle and acknowledges the release.

Each refresh takes one of two forms, chosen when the bus is handed over. A CAS-before-RAS cycle drops the shared column strobe ahead of the row strobe and uses the row counter inside the memory. A RAS-only cycle keeps the column strobe high and puts the block's own row counter on the address lines while the row strobe pulses. Owed refreshes are counted, so several can be postponed. Once the owed count reaches a set limit, an urgent flag tells the access controller to wind down. All pulse widths are given in clock cycles, and elaboration checks them against the memory's nanosecond minimums for the chosen clock period.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and for at least PAUSE_CYC cycles after it is released, ras_n and cas_n stay 1, and init_done, ref_req, ref_gnt, ref_urgent and row_oe stay 0.
- R2: After the pause, exactly INIT_REFS CAS-before-RAS cycles run back to back. They are CAS-before-RAS whatever ras_only_mode is, ref_gnt stays 0 throughout, and then init_done rises and stays 1 until reset.
- R3: In every CAS-before-RAS cycle, cas_n is 0 for exactly CAS_SETUP_CYC cycles with ras_n 1 before ras_n falls. cas_n stays 0 for exactly CAS_HOLD_CYC cycles after ras_n falls. ras_n stays 0 for RAS_LOW_CYC cycles. Both strobes then stay 1 for RAS_PRE_CYC cycles before the next strobe fall or the fall of ref_grant.
- R4: After init_done rises, one refresh becomes owed every INTERVAL_CYC cycles, the first one INTERVAL_CYC cycles after init_done. ref_req is 1 exactly while the owed count is non-zero.
- R5: ref_gnt rises only in the cycle after ctl_idle was sampled 1 while a refresh was owed. No strobe falls between that rise and the sampling of bus_ack as 1.
- R6: ref_urgent is 1 exactly while the owed count is at least MAX_POSTPONE.
- R7: Each granted cycle retires one owed refresh in the cycle in which ref_gnt falls. A tick of the interval timer and a retirement in the same cycle leave the owed count unchanged.
- R8: A cycle granted while ras_only_mode is 1 when bus_ack is sampled is a RAS-only cycle: cas_n stays 1, row_oe is 1 from the cycle before ras_n falls until ras_n rises, and row_addr holds steady while row_oe is 1.
- R9: row_addr is 0 after reset. It increases by one at the end of each RAS-only cycle and wraps from 2^ROW_W-1 to 0. CAS-before-RAS cycles leave it unchanged.
- R10: Once init_done is 1, ras_n or cas_n is 0 only while ref_gnt is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1 selects a RAS-only refresh for the next granted cycle, 0 selects CAS-before-RAS |
| ctl_idle | input | 1 | Access controller has no cycle in progress |
| bus_ack | input | 1 | Access controller has released the strobes and address lines |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Owed count has reached the postponement limit |
| ref_gnt | output | 1 | Sequencer owns the bus for a periodic refresh |
| init_done | output | 1 | Power-up sequence complete, memory usable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe shared by both byte lanes, active low |
| row_oe | output | 1 | row_addr is to be driven on the address lines |
| row_addr | output | ROW_W | Row for the RAS-only refresh |

## Verification
Two functions can fall in the same clock edge: the interval timer adding an owed refresh, and the end of a served cycle retiring one. The bench keeps its own owed count, advancing it every INTERVAL_CYC cycles after init_done and lowering it at each fall of ref_gnt, and compares ref_req and ref_urgent with that count on every cycle. To make the two events meet, it holds ctl_idle low from one tick and then releases it at a sweep of offsets before the next tick, so that the retirement lands before, on and after the tick. Any lost or doubled count then shows up as a mismatch.

// File: rtl/drs_pkg.sv
package drs_pkg;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_IDLE,
      ST_ARB,
      ST_SETUP,
      ST_STROBE,
      ST_PRECH
   } drs_state_e;

   // bits needed to hold values 0..n
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/drs_pacer.sv
module drs_pacer
   import drs_pkg::*;
#(
   parameter int INTERVAL_CYC = 1950,
   parameter int MAX_POSTPONE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic retire,
   output logic req_o,
   output logic urgent_o
);
   localparam int IW  = cnt_w(INTERVAL_CYC - 1);
   localparam int CAP = 2 * MAX_POSTPONE;
   localparam int PW  = cnt_w(CAP);

   logic [IW-1:0] tmr_q;
   logic [PW-1:0] owed_q;
   logic          tick;

   assign tick = run && (tmr_q == IW'(INTERVAL_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)           tmr_q <= '0;
      else if (!run || tick) tmr_q <= '0;
      else                  tmr_q <= tmr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owed_q <= '0;
      end else begin
         case ({tick, retire})
            2'b10:   if (owed_q != PW'(CAP)) owed_q <= owed_q + 1'b1;
            2'b01:   if (owed_q != '0)       owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
      end
   end

   assign req_o    = (owed_q != '0);
   assign urgent_o = (owed_q >= PW'(MAX_POSTPONE));

endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [ROW_W-1:0] row_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    row_o <= '0;
      else if (step) row_o <= row_o + 1'b1;
   end
endmodule

// File: rtl/drs_cycle_fsm.sv
module drs_cycle_fsm
   import drs_pkg::*;
#(
   parameter int PAUSE_CYC     = 12500,
   parameter int INIT_REFS     = 8,
   parameter int CAS_SETUP_CYC = 1,
   parameter int CAS_HOLD_CYC  = 2,
   parameter int RAS_LOW_CYC   = 8,
   parameter int RAS_PRE_CYC   = 5,
   parameter bit ROR_EN        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic owed,
   input  logic idle,
   input  logic ack,
   input  logic ror_sel,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic gnt_o,
   output logic ready_o,
   output logic row_oe_o,
   output logic retire_o,
   output logic row_step_o
);
   localparam int TMAX = max4(PAUSE_CYC, CAS_SETUP_CYC, RAS_LOW_CYC, RAS_PRE_CYC);
   localparam int TW   = cnt_w(TMAX);
   localparam int NW   = cnt_w(INIT_REFS);

   drs_state_e    state_q, state_d;
   logic [TW-1:0] tm_q, tm_d;
   logic [NW-1:0] left_q, left_d;
   logic          ror_q, ror_d;
   logic          ready_q, ready_d;
   logic          ras_d, cas_d, gnt_d, oe_d;

   always_comb begin
      state_d    = state_q;
      tm_d       = tm_q + 1'b1;
      left_d     = left_q;
      ror_d      = ror_q;
      ready_d    = ready_q;
      retire_o   = 1'b0;
      row_step_o = 1'b0;
      case (state_q)
         ST_PAUSE: begin
            if (tm_q == TW'(PAUSE_CYC - 1)) begin
               state_d = ST_SETUP;
               tm_d    = '0;
               ror_d   = 1'b0;
            end
         end
         ST_IDLE: begin
            tm_d = '0;
            if (owed && idle) state_d = ST_ARB;
         end
         ST_ARB: begin
            tm_d = '0;
            if (ack) begin
               state_d = ST_SETUP;
               ror_d   = ROR_EN && ror_sel;
            end
         end
         ST_SETUP: begin
            if (tm_q == TW'(CAS_SETUP_CYC - 1)) begin
               state_d = ST_STROBE;
               tm_d    = '0;
            end
         end
         ST_STROBE: begin
            if (tm_q == TW'(RAS_LOW_CYC - 1)) begin
               state_d = ST_PRECH;
               tm_d    = '0;
            end
         end
         ST_PRECH: begin
            if (tm_q == TW'(RAS_PRE_CYC - 1)) begin
               tm_d = '0;
               if (!ready_q) begin
                  left_d = left_q - 1'b1;
                  if (left_q == NW'(1)) begin
                     ready_d = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     state_d = ST_SETUP;
                  end
               end else begin
                  retire_o   = 1'b1;
                  row_step_o = ror_q;
                  state_d    = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // strobes decoded from the next state, then registered
   always_comb begin
      ras_d = (state_d != ST_STROBE);
      if (ror_d) cas_d = 1'b1;
      else       cas_d = !((state_d == ST_SETUP) ||
                           ((state_d == ST_STROBE) && (tm_d < TW'(CAS_HOLD_CYC))));
      gnt_d = ready_d && (state_d inside {ST_ARB, ST_SETUP, ST_STROBE, ST_PRECH});
      oe_d  = ror_d && (state_d inside {ST_SETUP, ST_STROBE});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_PAUSE;
         tm_q     <= '0;
         left_q   <= NW'(INIT_REFS);
         ror_q    <= 1'b0;
         ready_q  <= 1'b0;
         ras_n_o  <= 1'b1;
         cas_n_o  <= 1'b1;
         gnt_o    <= 1'b0;
         row_oe_o <= 1'b0;
      end else begin
         state_q  <= state_d;
         tm_q     <= tm_d;
         left_q   <= left_d;
         ror_q    <= ror_d;
         ready_q  <= ready_d;
         ras_n_o  <= ras_d;
         cas_n_o  <= cas_d;
         gnt_o    <= gnt_d;
         row_oe_o <= oe_d;
      end
   end

   assign ready_o = ready_q;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import drs_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 8000,
   parameter int PAUSE_CYC     = 12500,
   parameter int INIT_REFS     = 8,
   parameter int INTERVAL_CYC  = 1950,
   parameter int MAX_POSTPONE  = 4,
   parameter int CAS_SETUP_CYC = 1,
   parameter int CAS_HOLD_CYC  = 2,
   parameter int RAS_LOW_CYC   = 8,
   parameter int RAS_PRE_CYC   = 5,
   parameter int ROW_W         = 10,
   parameter bit RAS_ONLY_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_only_mode,
   input  logic             ctl_idle,
   input  logic             bus_ack,
   output logic             ref_req,
   output logic             ref_urgent,
   output logic             ref_gnt,
   output logic             init_done,
   output logic             ras_n,
   output logic             cas_n,
   output logic             row_oe,
   output logic [ROW_W-1:0] row_addr
);
   localparam int     CYCLE_CYC = CAS_SETUP_CYC + RAS_LOW_CYC + RAS_PRE_CYC;
   localparam longint ROWS      = longint'(1) << ROW_W;
   localparam longint PERIOD_PS = longint'(INTERVAL_CYC) * CLK_PERIOD_PS * ROWS;

   // elaboration-time parameter checks
   if (CAS_SETUP_CYC < 1 || CAS_SETUP_CYC * CLK_PERIOD_PS < 5000) begin : g_chk_setup
      $error("CAS setup before RAS shorter than 5 ns");
   end
   if (CAS_HOLD_CYC < 1 || CAS_HOLD_CYC * CLK_PERIOD_PS < 10000) begin : g_chk_hold
      $error("CAS hold after RAS shorter than 10 ns");
   end
   if (CAS_HOLD_CYC >= RAS_LOW_CYC) begin : g_chk_hold_fit
      $error("CAS hold must end inside the RAS low pulse");
   end
   if (RAS_LOW_CYC * CLK_PERIOD_PS < 60000) begin : g_chk_ras
      $error("RAS pulse shorter than 60 ns");
   end
   if (RAS_PRE_CYC * CLK_PERIOD_PS < 40000) begin : g_chk_pre
      $error("RAS precharge shorter than 40 ns");
   end
   if (CYCLE_CYC * CLK_PERIOD_PS < 110000) begin : g_chk_cycle
      $error("refresh cycle shorter than 110 ns");
   end
   if (INIT_REFS < 8) begin : g_chk_init
      $error("fewer than eight wake-up refresh cycles");
   end
   if (MAX_POSTPONE < 1) begin : g_chk_post
      $error("postponement limit must be at least one");
   end
   if (INTERVAL_CYC <= CYCLE_CYC + 2) begin : g_chk_int
      $error("refresh interval cannot hold one refresh cycle");
   end
   if (PERIOD_PS > 64'd16_000_000_000) begin : g_chk_period
      $error("all rows not covered within 16 ms");
   end
   if (PAUSE_CYC < 2) begin : g_chk_pause
      $error("power-up pause too short");
   end

   logic owed, retire, row_step;

   drs_pacer #(
      .INTERVAL_CYC(INTERVAL_CYC),
      .MAX_POSTPONE(MAX_POSTPONE)
   ) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (init_done),
      .retire  (retire),
      .req_o   (owed),
      .urgent_o(ref_urgent)
   );

   drs_cycle_fsm #(
      .PAUSE_CYC    (PAUSE_CYC),
      .INIT_REFS    (INIT_REFS),
      .CAS_SETUP_CYC(CAS_SETUP_CYC),
      .CAS_HOLD_CYC (CAS_HOLD_CYC),
      .RAS_LOW_CYC  (RAS_LOW_CYC),
      .RAS_PRE_CYC  (RAS_PRE_CYC),
      .ROR_EN       (RAS_ONLY_EN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .owed      (owed),
      .idle      (ctl_idle),
      .ack       (bus_ack),
      .ror_sel   (ras_only_mode),
      .ras_n_o   (ras_n),
      .cas_n_o   (cas_n),
      .gnt_o     (ref_gnt),
      .ready_o   (init_done),
      .row_oe_o  (row_oe),
      .retire_o  (retire),
      .row_step_o(row_step)
   );

   if (RAS_ONLY_EN) begin : g_row
      drs_row_ctr #(.ROW_W(ROW_W)) u_row (
         .clk  (clk),
         .rst_n(rst_n),
         .step (row_step),
         .row_o(row_addr)
      );
   end else begin : g_no_row
      assign row_addr = '0;
   end

   assign ref_req = owed;

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int ROW_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_idle,
   input logic             ref_req,
   input logic             ref_gnt,
   input logic             init_done,
   input logic             ras_n,
   input logic             cas_n,
   input logic             row_oe,
   input logic [ROW_W-1:0] row_addr
);
   localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

   assert_gnt_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_gnt) |-> $past(ctl_idle) && $past(ref_req));

   assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !row_oe) |-> (!cas_n && $past(!cas_n)));

   assert_ror_cas_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      row_oe |-> cas_n);

   assert_ror_row_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (row_oe && $past(row_oe)) |-> $stable(row_addr));

   assert_owner_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && (!ras_n || !cas_n)) |-> ref_gnt);

   assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (row_addr != $past(row_addr)) |-> (row_addr == $past(row_addr) + ONE));

   assert_quiet_pre_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> (!ref_gnt && !ref_req));

endmodule

bind dram_refresh_seq drs_checker #(.ROW_W(ROW_W)) u_drs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_idle (ctl_idle),
   .ref_req  (ref_req),
   .ref_gnt  (ref_gnt),
   .init_done(init_done),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .row_oe   (row_oe),
   .row_addr (row_addr)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
   localparam int PAUSE    = 300;
   localparam int INIT     = 8;
   localparam int INTERVAL = 120;
   localparam int MAXP     = 3;
   localparam int SETUP    = 1;
   localparam int HOLD     = 2;
   localparam int RLOW     = 8;
   localparam int RPRE     = 5;
   localparam int RW       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_only_mode = 1'b0;
   logic ctl_idle = 1'b0;
   logic bus_ack = 1'b0;
   logic ref_req, ref_urgent, ref_gnt, init_done, ras_n, cas_n, row_oe;
   logic [RW-1:0] row_addr;

   always #4 clk = ~clk;

   dram_refresh_seq #(
      .PAUSE_CYC(PAUSE), .INIT_REFS(INIT), .INTERVAL_CYC(INTERVAL),
      .MAX_POSTPONE(MAXP), .CAS_SETUP_CYC(SETUP), .CAS_HOLD_CYC(HOLD),
      .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(RPRE), .ROW_W(RW)
   ) i_dram_refresh_seq (
      .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode),
      .ctl_idle(ctl_idle), .bus_ack(bus_ack), .ref_req(ref_req),
      .ref_urgent(ref_urgent), .ref_gnt(ref_gnt), .init_done(init_done),
      .ras_n(ras_n), .cas_n(cas_n), .row_oe(row_oe), .row_addr(row_addr)
   );

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   task automatic chk(input string req, input bit ok, input longint act,
                      input longint exp, input string what);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- negedge monitor and owed-refresh model ----------------
   bit  prev_ras = 1, prev_cas = 1, prev_gnt = 0;
   int  ras_falls = 0, cbr_cnt = 0, ror_cnt = 0, gnt_rises = 0;
   int  setup_ctr = 0, low_ctr = 0, ovl_ctr = 0, gap_ctr = 0;
   bit  in_gap = 0;
   int  last_setup = -1, last_low = -1, last_ovl = -1, last_gap = -1;
   int  last_ror_row = -1;
   bit  last_ror_oe = 0;
   bit  seen_ready = 0;
   int  nready = 0, owed = 0;
   int  mism_req = 0, mism_urg = 0, mism_row = 0;
   int  prev_row = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ras_n && !cas_n) setup_ctr++;
         if (prev_ras && !ras_n) begin
            ras_falls++;
            last_setup = setup_ctr;
            setup_ctr  = 0;
            low_ctr    = 1;
            ovl_ctr    = cas_n ? 0 : 1;
            if (!cas_n) cbr_cnt++;
            else begin
               ror_cnt++;
               last_ror_row = row_addr;
               last_ror_oe  = row_oe;
            end
            if (in_gap) begin last_gap = gap_ctr; in_gap = 0; end
         end else if (!ras_n) begin
            low_ctr++;
            if (!cas_n) ovl_ctr++;
         end else if (!prev_ras && ras_n) begin
            last_low = low_ctr;
            last_ovl = ovl_ctr;
            in_gap   = 1;
            gap_ctr  = 1;
         end else if (in_gap) begin
            if (!cas_n || (prev_gnt && !ref_gnt)) begin
               last_gap = gap_ctr;
               in_gap   = 0;
            end else gap_ctr++;
         end
         if (!prev_gnt && ref_gnt) gnt_rises++;
         // owed model
         if (init_done) begin
            if (!seen_ready) begin seen_ready = 1; nready = 0; end
            else nready++;
            if (nready > 0 && (nready % INTERVAL) == 0) owed++;
            if (prev_gnt && !ref_gnt) owed--;
            if (ref_req != (owed > 0)) mism_req++;
            if (ref_urgent != (owed >= MAXP)) mism_urg++;
         end else if (ref_req || ref_urgent) mism_req++;
         if (row_addr != prev_row[RW-1:0] &&
             int'(row_addr) != ((prev_row + 1) % (1 << RW))) mism_row++;
         prev_row = row_addr;
         prev_ras = ras_n;
         prev_cas = cas_n;
         prev_gnt = ref_gnt;
      end
   end

   // ---------------- scenarios ----------------
   task automatic t_reset();
      repeat (4) @(negedge clk);
      chk("R1", ras_n && cas_n, {ras_n, cas_n}, 3, "strobes in reset");
      chk("R1", !init_done && !ref_req && !ref_gnt && !ref_urgent && !row_oe,
          {init_done, ref_req, ref_gnt, ref_urgent, row_oe}, 0, "flags in reset");
      chk("R9", row_addr == 0, row_addr, 0, "row counter in reset");
      rst_n = 1'b1;
   endtask

   task automatic t_init();
      int cnt = 0;
      ras_only_mode = 1'b1;   // must be ignored for wake-up cycles
      do begin @(negedge clk); cnt++; end while (cas_n && cnt < 20000);
      chk("R1", cnt >= PAUSE, cnt, PAUSE, "cycles before first strobe");
      chk("R1", !init_done, init_done, 0, "ready during pause");
      do @(negedge clk); while (!init_done);
      chk("R2", cbr_cnt == INIT && ras_falls == INIT, cbr_cnt, INIT, "wake-up CBR cycles");
      chk("R2", ror_cnt == 0, ror_cnt, 0, "RAS-only cycles during wake-up");
      chk("R2", gnt_rises == 0, gnt_rises, 0, "grant during wake-up");
      chk("R3", last_setup == SETUP, last_setup, SETUP, "CAS setup cycles");
      chk("R3", last_ovl == HOLD, last_ovl, HOLD, "CAS hold after RAS fall");
      chk("R3", last_low == RLOW, last_low, RLOW, "RAS low cycles");
      chk("R3", last_gap == RPRE, last_gap, RPRE, "precharge between wake-up cycles");
      ras_only_mode = 1'b0;
   endtask

   task automatic t_interval();
      int cnt = 0;
      int f0 = ras_falls;
      do begin @(negedge clk); cnt++; end while (!ref_req && cnt < 2000);
      chk("R4", cnt == INTERVAL, cnt, INTERVAL, "cycles from ready to first request");
      do begin @(negedge clk); cnt++; end while (!ref_urgent && cnt < 2000);
      chk("R6", cnt == MAXP * INTERVAL, cnt, MAXP * INTERVAL, "cycles until urgent");
      chk("R5", gnt_rises == 0 && ras_falls == f0, gnt_rises, 0, "grant while controller busy");
      chk("R4", mism_req == 0, mism_req, 0, "request tracks owed count");
   endtask

   task automatic t_serve();
      int f0 = ras_falls, g0 = gnt_rises, c0 = cbr_cnt, w = 0;
      ctl_idle = 1'b1;
      @(negedge clk);
      chk("R5", ref_gnt == 1'b1, ref_gnt, 1, "grant one cycle after idle");
      repeat (10) @(negedge clk);
      chk("R5", ras_falls == f0 && ras_n && cas_n, ras_falls - f0, 0, "strobes before bus_ack");
      bus_ack = 1'b1;
      do begin @(negedge clk); w++; end while (ref_req && w < 500);
      chk("R7", cbr_cnt - c0 == MAXP, cbr_cnt - c0, MAXP, "owed refreshes served");
      chk("R7", gnt_rises - g0 == MAXP, gnt_rises - g0, MAXP, "one grant per refresh");
      chk("R6", ref_urgent == 1'b0, ref_urgent, 0, "urgent after catching up");
      chk("R3", last_gap == RPRE, last_gap, RPRE, "precharge before grant drop");
      chk("R6", mism_urg == 0, mism_urg, 0, "urgent tracks owed count");
   endtask

   task automatic t_ror();
      int r0 = ror_cnt, w = 0;
      ras_only_mode = 1'b1;
      do begin @(negedge clk); w++; end while (ror_cnt == r0 && w < 500);
      chk("R8", ror_cnt == r0 + 1 && cas_n, cas_n, 1, "RAS-only cycle with CAS high");
      chk("R8", last_ror_oe == 1'b1, last_ror_oe, 1, "row drive at RAS fall");
      chk("R9", last_ror_row == 0, last_ror_row, 0, "first RAS-only row");
      do @(negedge clk); while (ref_gnt);
      chk("R9", row_addr == 1, row_addr, 1, "row after first RAS-only cycle");
   endtask

   task automatic t_wrap();
      int w = 0;
      do begin @(negedge clk); w++; end while (ror_cnt < (1 << RW) && w < 5000);
      do @(negedge clk); while (ref_gnt);
      chk("R9", row_addr == 0, row_addr, 0, "row wrap to zero");
      chk("R9", mism_row == 0, mism_row, 0, "row steps by one");
   endtask

   task automatic t_cbr_keeps_row();
      int c0 = cbr_cnt, w = 0;
      logic [RW-1:0] r0 = row_addr;
      ras_only_mode = 1'b0;
      do begin @(negedge clk); w++; end while (cbr_cnt == c0 && w < 500);
      do @(negedge clk); while (ref_gnt);
      chk("R9", row_addr == r0, row_addr, r0, "row after CBR cycle");
   endtask

   task automatic t_collide();
      for (int off = 0; off < 8; off++) begin
         ctl_idle = 1'b0;
         do @(negedge clk); while ((nready % INTERVAL) != 0);
         do @(negedge clk); while ((nready % INTERVAL) != INTERVAL - 20 + off);
         ctl_idle = 1'b1;
         repeat (40) @(negedge clk);
      end
      chk("R7", mism_req == 0, mism_req, 0, "request with tick and retire together");
      chk("R7", mism_urg == 0, mism_urg, 0, "urgent with tick and retire together");
      chk("R4", ref_req == 1'b0, ref_req, 0, "nothing owed after sweep");
   endtask

   initial begin
      t_reset();
      t_init();
      t_interval();
      t_serve();
      t_ror();
      t_wrap();
      t_cbr_keeps_row();
      t_collide();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (R1..): actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule